// File: doc/BRIEF.md
# Decoupling Instruction Dispatcher

This block sits between an in-order instruction fetch stage and three independent execution engines: an address engine that performs every memory access, a vector compute engine and a scalar compute engine. It accepts one decoded instruction descriptor per cycle over a valid/ready handshake. Each descriptor is rewritten into one or two entries, and each entry is written into a 16-deep instruction queue that belongs to one engine. The engines drain their queues with a pop/valid interface.

A memory instruction becomes two linked entries. The access itself goes to the address queue. A queue-move goes to the compute engine that owns the data. For a load, the queue-move tells that engine to pop its incoming data queue into a register. For a store, it tells the engine to push a register out toward the address engine. A compute instruction that reads an operand owned by the other compute engine also gets a partner entry. That entry is a push-style queue-move, sent to the engine that owns the operand.

An internal holding register carries the instruction under dispatch. A state machine steps through three states. OPEN means nothing is held. ISSUE means an instruction is held and is being offered to its queues. STALL means the held instruction has been blocked by a full queue. The transitions are:
- take: OPEN to ISSUE.
- stream: ISSUE to ISSUE, issuing one instruction and accepting the next.
- drain: ISSUE or STALL to OPEN, issuing with no new input.
- block: ISSUE to STALL.
- wait: STALL to STALL.
- release: STALL to ISSUE, issuing while accepting.

Top module: `decoupling_dispatcher`

## Requirements
- R1: An instruction with kind 0 (vector compute) and in_xop low writes exactly one entry, op code 0 (execute) followed by its tag, to the vector queue only.
- R2: An instruction with kind 1 (scalar compute) and in_xop low writes exactly one entry, op code 0 followed by its tag, to the scalar queue only.
- R3: A kind 2 (load) instruction writes op code 1 with its tag to the address queue. It also writes op code 3 (pop data into register) with its tag to the vector queue when in_vec is 1, or to the scalar queue when in_vec is 0.
- R4: A kind 3 (store) instruction writes op code 2 with its tag to the address queue. It also writes op code 4 (push register out) with its tag to the vector queue when in_vec is 1, or to the scalar queue when in_vec is 0.
- R5: A compute instruction with in_xop high writes its op code 0 entry to its own queue. It also writes op code 4 with the same tag to the other compute queue.
- R6: All entries produced by one instruction enter their queues in the same cycle, or none enter. An address-queue write never happens without its queue-move partner.
- R7: While any queue needed by the held instruction is full, the held instruction is kept unchanged, in_ready is low, and no entry of it or of any later instruction reaches any queue.
- R8: Within each queue, entries leave in the order their instructions were accepted. No entry appears that was not produced by R1 to R5.
- R9: Each queue holds 16 entries before it reports full, and it is never written while full.
- R10: After reset all queues are empty and in_ready is high. At most one instruction is accepted per clock, and an accepted instruction is held in the following cycle.
- R11: in_xop has no effect on load and store instructions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction descriptor valid |
| in_ready | output | 1 | Dispatcher can take a descriptor this cycle |
| in_kind | input | 2 | 0 vector compute, 1 scalar compute, 2 load, 3 store |
| in_vec | input | 1 | Memory data side: 1 vector engine, 0 scalar engine |
| in_xop | input | 1 | Compute operand owned by the other compute engine |
| in_tag | input | TAG_W | Opaque instruction payload carried into every entry |
| aq_pop | input | 1 | Address engine takes the head entry |
| aq_valid | output | 1 | Address queue not empty |
| aq_data | output | TAG_W+3 | Address queue head: op code in top 3 bits, tag below |
| vq_pop | input | 1 | Vector engine takes the head entry |
| vq_valid | output | 1 | Vector queue not empty |
| vq_data | output | TAG_W+3 | Vector queue head entry |
| sq_pop | input | 1 | Scalar engine takes the head entry |
| sq_valid | output | 1 | Scalar queue not empty |
| sq_data | output | TAG_W+3 | Scalar queue head entry |

## Verification
The bench fills the vector queue to its sixteenth entry and then offers a seventeenth instruction, followed by a scalar instruction. It watches for two faults: a dispatcher that overflows the queue, and one that lets the unrelated scalar entry slip past the blocked instruction. It also holds the address queue full and then offers a vector load. A design that splits the pair would leave a lone queue-move in the vector queue. Loads and stores carrying a stray in_xop, and mixed streams in which every instruction kind alternates, expose misrouted entries, lost entries and entries reordered within a queue.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int NQ  = 3;
    localparam int QA  = 0;
    localparam int QV  = 1;
    localparam int QS  = 2;
    localparam int OPW = 3;

    typedef enum logic [1:0] {
        K_VOP   = 2'd0,
        K_SOP   = 2'd1,
        K_LOAD  = 2'd2,
        K_STORE = 2'd3
    } kind_e;

    typedef enum logic [OPW-1:0] {
        E_EXEC  = 3'd0,
        E_LOAD  = 3'd1,
        E_STORE = 3'd2,
        E_QPOP  = 3'd3,
        E_QPUSH = 3'd4
    } entry_e;

    typedef struct packed {
        kind_e kind;
        logic  vec;
        logic  xop;
    } desc_t;

    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_STALL = 2'd2
    } state_e;

endpackage

// File: rtl/dq_fifo.sv
module dq_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    output logic         full,
    input  logic         pop,
    output logic         rvalid,
    output logic [W-1:0] rdata
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign rvalid  = (cnt != '0);
    assign rdata   = mem[rp];
    assign do_push = push && !full;
    assign do_pop  = pop && rvalid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

endmodule

// File: rtl/disp_route.sv
module disp_route
    import disp_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  desc_t                                d,
    input  logic [TAG_W-1:0]                     tag,
    output logic [NQ-1:0]                        need,
    output logic [NQ-1:0][TAG_W+OPW-1:0]         word
);
    always_comb begin
        int side;
        side = d.vec ? QV : QS;
        need = '0;
        word = '0;
        unique case (d.kind)
            K_VOP: begin
                need[QV] = 1'b1;
                word[QV] = {E_EXEC, tag};
                if (d.xop) begin
                    need[QS] = 1'b1;
                    word[QS] = {E_QPUSH, tag};
                end
            end
            K_SOP: begin
                need[QS] = 1'b1;
                word[QS] = {E_EXEC, tag};
                if (d.xop) begin
                    need[QV] = 1'b1;
                    word[QV] = {E_QPUSH, tag};
                end
            end
            K_LOAD: begin
                need[QA]   = 1'b1;
                word[QA]   = {E_LOAD, tag};
                need[side] = 1'b1;
                word[side] = {E_QPOP, tag};
            end
            K_STORE: begin
                need[QA]   = 1'b1;
                word[QA]   = {E_STORE, tag};
                need[side] = 1'b1;
                word[side] = {E_QPUSH, tag};
            end
            default: begin
                need = '0;
            end
        endcase
    end

endmodule

// File: rtl/disp_issue.sv
module disp_issue
    import disp_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  desc_t            in_d,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [NQ-1:0]    need,
    input  logic [NQ-1:0]    q_full,
    output logic [NQ-1:0]    q_push,
    output logic             hold_v,
    output desc_t            hold_d,
    output logic [TAG_W-1:0] hold_tag
);
    state_e state, nxt;
    logic   room, fire, accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OPEN;
        else        state <= nxt;
    end

    always_comb begin
        room     = ((need & q_full) == '0);
        fire     = (state != ST_OPEN) && room;
        in_ready = (state == ST_OPEN) || fire;
        accept   = in_valid && in_ready;
        q_push   = fire ? need : '0;
        hold_v   = (state != ST_OPEN);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OPEN:  nxt = accept ? ST_ISSUE : ST_OPEN;
            ST_ISSUE: nxt = accept ? ST_ISSUE : (fire ? ST_OPEN : ST_STALL);
            ST_STALL: nxt = accept ? ST_ISSUE : (fire ? ST_OPEN : ST_STALL);
            default:  nxt = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_d   <= '0;
            hold_tag <= '0;
        end else if (accept) begin
            hold_d   <= in_d;
            hold_tag <= in_tag;
        end
    end

endmodule

// File: rtl/decoupling_dispatcher.sv
module decoupling_dispatcher
    import disp_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [1:0]         in_kind,
    input  logic               in_vec,
    input  logic               in_xop,
    input  logic [TAG_W-1:0]   in_tag,
    input  logic               aq_pop,
    output logic               aq_valid,
    output logic [TAG_W+2:0]   aq_data,
    input  logic               vq_pop,
    output logic               vq_valid,
    output logic [TAG_W+2:0]   vq_data,
    input  logic               sq_pop,
    output logic               sq_valid,
    output logic [TAG_W+2:0]   sq_data
);
    localparam int EW = TAG_W + OPW;

    desc_t                in_d;
    desc_t                hold_d;
    logic [TAG_W-1:0]     hold_tag;
    logic                 hold_v;
    logic [NQ-1:0]        need, q_full, q_push, q_pop, q_valid;
    logic [NQ-1:0][EW-1:0] q_word, q_head;

    assign in_d = '{kind: kind_e'(in_kind), vec: in_vec, xop: in_xop};

    disp_route #(.TAG_W(TAG_W)) u_route (
        .d    (hold_d),
        .tag  (hold_tag),
        .need (need),
        .word (q_word)
    );

    disp_issue #(.TAG_W(TAG_W)) u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_d     (in_d),
        .in_tag   (in_tag),
        .need     (need),
        .q_full   (q_full),
        .q_push   (q_push),
        .hold_v   (hold_v),
        .hold_d   (hold_d),
        .hold_tag (hold_tag)
    );

    assign q_pop[QA] = aq_pop;
    assign q_pop[QV] = vq_pop;
    assign q_pop[QS] = sq_pop;

    for (genvar q = 0; q < NQ; q++) begin : g_q
        dq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
            .clk    (clk),
            .rst_n  (rst_n),
            .push   (q_push[q]),
            .wdata  (q_word[q]),
            .full   (q_full[q]),
            .pop    (q_pop[q]),
            .rvalid (q_valid[q]),
            .rdata  (q_head[q])
        );
    end

    assign aq_valid = q_valid[QA];
    assign aq_data  = q_head[QA];
    assign vq_valid = q_valid[QV];
    assign vq_data  = q_head[QV];
    assign sq_valid = q_valid[QS];
    assign sq_data  = q_head[QS];

endmodule

// File: rtl/disp_chk.sv
module disp_chk
    import disp_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [NQ-1:0]    q_push,
    input logic [NQ-1:0]    q_full,
    input logic             hold_v,
    input desc_t            hold_d,
    input logic [TAG_W-1:0] hold_tag
);
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push & q_full) == '0);

    // R6
    pair_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_push[QA] |-> (q_push[QV] ^ q_push[QS]));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_v && !in_ready) |=> (hold_v && $stable(hold_d) && $stable(hold_tag)));

    // R7
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (q_push == '0));

    // R10
    accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> hold_v);

endmodule

bind decoupling_dispatcher disp_chk #(.TAG_W(TAG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .q_push   (q_push),
    .q_full   (q_full),
    .hold_v   (hold_v),
    .hold_d   (hold_d),
    .hold_tag (hold_tag)
);

// File: tb/tb_decoupling_dispatcher.sv
`timescale 1ns/1ps
module tb_decoupling_dispatcher;
    localparam int TAG_W = 8;
    localparam int EW    = TAG_W + 3;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_ready, in_vec, in_xop;
    logic [1:0] in_kind;
    logic [TAG_W-1:0] in_tag;
    logic aq_pop, aq_valid, vq_pop, vq_valid, sq_pop, sq_valid;
    logic [EW-1:0] aq_data, vq_data, sq_data;

    logic [2:0] pop_en;
    logic [EW-1:0] exp_a[$], exp_v[$], exp_s[$];
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    decoupling_dispatcher #(.TAG_W(TAG_W), .DEPTH(16)) dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected entries come from R1..R5 and R11 encodings
    task automatic send(input logic [1:0] k, input logic v, input logic x, input logic [TAG_W-1:0] t);
        logic [EW-1:0] e_exec, e_ld, e_st, e_pop, e_push;
        e_exec = {3'd0, t}; e_ld = {3'd1, t}; e_st = {3'd2, t};
        e_pop  = {3'd3, t}; e_push = {3'd4, t};
        case (k)
            2'd0: begin exp_v.push_back(e_exec); if (x) exp_s.push_back(e_push); end // R1 R5
            2'd1: begin exp_s.push_back(e_exec); if (x) exp_v.push_back(e_push); end // R2 R5
            2'd2: begin exp_a.push_back(e_ld);                                      // R3 R11
                        if (v) exp_v.push_back(e_pop); else exp_s.push_back(e_pop); end
            default: begin exp_a.push_back(e_st);                                   // R4 R11
                        if (v) exp_v.push_back(e_push); else exp_s.push_back(e_push); end
        endcase
        @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_vec = v; in_xop = x; in_tag = t;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #0.5;
        in_valid = 1'b0;
    endtask

    // Monitor: R8 content and order per queue
    initial begin
        aq_pop = 1'b0; vq_pop = 1'b0; sq_pop = 1'b0;
        forever begin
            @(negedge clk);
            aq_pop = 1'b0; vq_pop = 1'b0; sq_pop = 1'b0;
            if (rst_n) begin
                if (pop_en[0] && aq_valid) begin
                    aq_pop = 1'b1;
                    if (exp_a.size() == 0) chk(1'b0, "R8 addr unexpected", int'(aq_data), 0);
                    else begin logic [EW-1:0] e; e = exp_a.pop_front();
                        chk(aq_data == e, "R8 addr entry", int'(aq_data), int'(e)); end
                end
                if (pop_en[1] && vq_valid) begin
                    vq_pop = 1'b1;
                    if (exp_v.size() == 0) chk(1'b0, "R8 vec unexpected", int'(vq_data), 0);
                    else begin logic [EW-1:0] e; e = exp_v.pop_front();
                        chk(vq_data == e, "R8 vec entry", int'(vq_data), int'(e)); end
                end
                if (pop_en[2] && sq_valid) begin
                    sq_pop = 1'b1;
                    if (exp_s.size() == 0) chk(1'b0, "R8 scal unexpected", int'(sq_data), 0);
                    else begin logic [EW-1:0] e; e = exp_s.pop_front();
                        chk(sq_data == e, "R8 scal entry", int'(sq_data), int'(e)); end
                end
            end
        end
    end

    task automatic drain();
        for (int i = 0; i < 300; i++) begin
            if (exp_a.size() == 0 && exp_v.size() == 0 && exp_s.size() == 0) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk(exp_a.size() + exp_v.size() + exp_s.size() == 0, "R8 all entries seen",
            exp_a.size() + exp_v.size() + exp_s.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_kind = 2'd0; in_vec = 1'b0; in_xop = 1'b0;
        in_tag = '0; pop_en = 3'b111;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R10 reset state
        chk(in_ready == 1'b1, "R10 ready after reset", int'(in_ready), 1);
        chk({aq_valid, vq_valid, sq_valid} == 3'b000, "R10 queues empty",
            int'({aq_valid, vq_valid, sq_valid}), 0);

        // R1 R2 R3 R4 R5 R11 directed
        send(2'd0, 1'b0, 1'b0, 8'h01);
        send(2'd1, 1'b0, 1'b0, 8'h02);
        send(2'd0, 1'b0, 1'b1, 8'h03);
        send(2'd1, 1'b0, 1'b1, 8'h04);
        send(2'd2, 1'b1, 1'b0, 8'h05);
        send(2'd2, 1'b0, 1'b0, 8'h06);
        send(2'd3, 1'b1, 1'b0, 8'h07);
        send(2'd3, 1'b0, 1'b0, 8'h08);
        send(2'd2, 1'b1, 1'b1, 8'h09);
        send(2'd3, 1'b0, 1'b1, 8'h0A);
        drain();

        // R8 R10 mixed back-to-back stream
        for (int i = 0; i < 40; i++)
            send(2'(i % 4), 1'((i / 4) % 2), 1'((i / 3) % 2), 8'(8'h20 + i));
        drain();

        // R9 depth, R7 stall blocks later instructions
        pop_en[1] = 1'b0;
        for (int i = 0; i < 16; i++) send(2'd0, 1'b0, 1'b0, 8'(8'h80 + i));
        repeat (4) @(negedge clk);
        #1;
        chk(in_ready == 1'b1, "R9 sixteen entries fit", int'(in_ready), 1);
        send(2'd0, 1'b0, 1'b0, 8'h90);
        repeat (3) @(negedge clk);
        #1;
        chk(in_ready == 1'b0, "R7 ready low when full", int'(in_ready), 0);
        fork
            send(2'd1, 1'b0, 1'b0, 8'h91);
        join_none
        repeat (10) @(negedge clk);
        #1;
        chk(sq_valid == 1'b0, "R7 later instruction held back", int'(sq_valid), 0);
        chk(in_ready == 1'b0, "R7 still stalled", int'(in_ready), 0);
        pop_en[1] = 1'b1;
        wait fork;
        drain();

        // R6 all-or-none with address queue full
        pop_en[0] = 1'b0;
        for (int i = 0; i < 16; i++) send(2'd2, 1'b0, 1'b0, 8'(8'hA0 + i));
        repeat (4) @(negedge clk);
        send(2'd2, 1'b1, 1'b0, 8'hB0);
        repeat (8) @(negedge clk);
        #1;
        chk(vq_valid == 1'b0, "R6 partner not pushed alone", int'(vq_valid), 0);
        chk(in_ready == 1'b0, "R6 pair blocked", int'(in_ready), 0);
        pop_en[0] = 1'b1;
        drain();

        @(negedge clk);
        #1;
        chk({aq_valid, vq_valid, sq_valid} == 3'b000, "R8 no extra entries",
            int'({aq_valid, vq_valid, sq_valid}), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule